// File: doc/BRIEF.md
# Command-Driven Quad SPI Transfer Engine

This block is a half-duplex serial flash master driven entirely by register writes. Software programs a clock-control register (enable plus divider) and a device-control register that holds one configuration byte per chip select. For a write it loads up to four 32-bit data registers. It then writes a command register, and each accepted command moves exactly one word of 1 to 128 bits over the serial lines.

Words are sent on one line, or received on one, two or four lines. Consecutive commands share a frame counter, so the chip select stays asserted across all the words of a frame. It is released when the programmed number of words has completed or when an end-of-frame command arrives. A status register reports busy and word-complete, and software polls these between commands.

Top module: `qspi_cmd_engine`

## Requirements
- R1: After reset every register reads zero, all chip-select lines sit at their deasserted level (high, since every polarity bit is 0), SCLK is low and the data-line driver enable is low.
- R2: Word addresses are: 0 clock control, 1 device control, 2 command, 3 status (read only), 4..7 data registers 0..3. Clock control, device control and the data registers read back the value last written.
- R3: Command fields: chip select in bits 29:28, word length minus one (bits) in 25:19, frame length minus one (words) in 11:0, operation code in 18:16. Code 1 is a one-line read, 2 a one-line write, 3 a two-line read, 7 a four-line read and 4 ends the frame. Any other code starts nothing and leaves the chip selects untouched.
- R4: Clock control bit 31 enables SCLK and bits 15:0 hold a divider D. Each SCLK half-period lasts D+1 clock cycles, so D=0 gives half the clock rate. A word of W bits moved k bits per SCLK period keeps busy high for exactly (W/k)*2*(D+1) cycles.
- R5: A write sends the low W bits of the 128-bit value {data3,data2,data1,data0}, most significant bit first, on dataOut. A 128-bit word therefore starts with bit 31 of data register 3. dataOe is high while a write is in progress and low during reads.
- R6: A one-line read samples dataIn[1] once per SCLK period, MSB first. The W received bits are right-justified in the data registers (data register 0 alone for W up to 32) and all higher bits read zero.
- R7: A two-line read samples dataIn[1:0] and a four-line read samples dataIn[3:0] once per SCLK period, with the higher-numbered line carrying the more significant bit. The result is placed as in R6.
- R8: Device-control byte n (bits 8n+7:8n) configures chip select n. Bit 0 is the clock polarity and sets the idle SCLK level; bit 2 is the clock phase. With phase 0 data is sampled on the first edge of each bit period, and with phase 1 on the second edge. Exactly W/k sampling edges occur per word.
- R9: Device-control bit 8n+1 set makes chip select n active-high. The selected chip select asserts on the first command of a frame, stays asserted between the words of the frame, and deasserts when frame-length words have completed.
- R10: An end-of-frame command deasserts the chip select at once, even before the programmed word count has been reached.
- R11: Status bit 0 (busy) is high from the accepted command until the word completes. Status bit 1 (word complete) then sets and is cleared by the next command write.
- R12: A command written while busy is ignored: the running word keeps its timing, no second word follows, and the command register keeps its previous value.
- R13: With clock control bit 31 clear, an accepted command holds busy high and SCLK at its idle level without progress. Setting the bit lets the word run to completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| sclk | output | 1 | Serial clock |
| csOut | output | 4 | Chip-select lines, polarity per device-control byte |
| dataOut | output | 1 | Serial write data on line 0 |
| dataOe | output | 1 | Drive enable for dataOut |
| dataIn | input | 4 | Serial read data lines 3..0 |

## Verification
The hardest state to reach is a command arriving in the middle of a running word. The bench issues it a few cycles after a slow-clocked 32-bit write has started and checks that the busy window keeps the first word's exact length and that the command register is unchanged. Dual and quad reads with a 128-bit word and phase 1 need a bus device that reacts to SCLK itself. The bench models one that shifts its own pattern out on every sampling edge, so all four polarity/phase combinations, three divider values, four operations and four word lengths are swept against arithmetic expectations.

// File: rtl/qspi_eng_pkg.sv
package qspi_eng_pkg;
  localparam int WORD_MAX  = 128;
  localparam int WLEN_W    = $clog2(WORD_MAX);
  localparam int FRAME_MAX = 4096;
  localparam int FLEN_W    = $clog2(FRAME_MAX);
  localparam int REG_W     = 32;
  localparam int NUM_DREG  = WORD_MAX / REG_W;
  localparam int DSEL_W    = $clog2(NUM_DREG);
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] A_CLK   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DEV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA0 = 3'd4;

  localparam int CMD_OP_LSB = 16;
  localparam int CMD_WL_LSB = 19;
  localparam int CMD_CS_LSB = 28;
  localparam int CLK_EN_BIT = 31;

  localparam logic [2:0] OP_RD1 = 3'd1;
  localparam logic [2:0] OP_WR1 = 3'd2;
  localparam logic [2:0] OP_RD2 = 3'd3;
  localparam logic [2:0] OP_END = 3'd4;
  localparam logic [2:0] OP_RD4 = 3'd7;

  typedef struct packed {
    logic              load;      // align write word to the MSB end
    logic              clear;     // zero the shift register before a read
    logic              shiftOut;  // advance to the next write bit
    logic              sampleIn;  // capture read lines
    logic [1:0]        lanes;     // 0: one line, 1: two, 2: four
    logic [WLEN_W-1:0] alignAmt;
  } dpCtrl_t;
endpackage

// File: rtl/qspi_eng_dp.sv
module qspi_eng_dp
  import qspi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  dpCtrl_t           dpCtrl,
  input  logic [3:0]        dataIn,
  output logic [REG_W-1:0]  dataRd,
  output logic              dataOut
);
  logic [WORD_MAX-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (dpCtrl.load) begin
      shiftQ <= shiftQ << dpCtrl.alignAmt;
    end else if (dpCtrl.clear) begin
      shiftQ <= '0;
    end else if (dpCtrl.sampleIn) begin
      case (dpCtrl.lanes)
        2'd1:    shiftQ <= {shiftQ[WORD_MAX-3:0], dataIn[1:0]};
        2'd2:    shiftQ <= {shiftQ[WORD_MAX-5:0], dataIn[3:0]};
        default: shiftQ <= {shiftQ[WORD_MAX-2:0], dataIn[1]};
      endcase
    end else if (dpCtrl.shiftOut) begin
      shiftQ <= shiftQ << 1;
    end else if (regWrEn) begin
      for (int k = 0; k < NUM_DREG; k++) begin
        if (regAddr == ADDR_W'(int'(A_DATA0) + k)) shiftQ[REG_W*k +: REG_W] <= regWrData;
      end
    end
  end

  assign dataRd  = shiftQ[REG_W*int'(regAddr[DSEL_W-1:0]) +: REG_W];
  assign dataOut = shiftQ[WORD_MAX-1];

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dpCtrl.load, dpCtrl.clear, dpCtrl.shiftOut, dpCtrl.sampleIn})); // R3
endmodule

// File: rtl/qspi_eng_ctrl.sv
module qspi_eng_ctrl
  import qspi_eng_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  clkCtrlQ,
  output logic [REG_W-1:0]  devCtrlQ,
  output logic [REG_W-1:0]  cmdQ,
  output logic [REG_W-1:0]  statusQ,
  output dpCtrl_t           dpCtrl,
  output logic              sclk,
  output logic [NUM_CS-1:0] csOut,
  output logic              dataOe
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic              busy, frameOn, wordDone, half;
  logic [DIV_W-1:0]  divCnt;
  logic [WLEN_W:0]   edgesLeft, edgesInit;
  logic [FLEN_W-1:0] frameCnt, frameLast;
  logic [CS_W-1:0]   selCs;
  logic [2:0]        opQ, newOp;
  logic [1:0]        newLanes;
  logic [WLEN_W-1:0] newWlm1;
  logic              cmdWr, accept, endFrame, clkEn, phaseEnd, isWrite;
  logic              cpolSel, cphaSel;

  assign cmdWr    = regWrEn && (regAddr == A_CMD);
  assign newOp    = regWrData[CMD_OP_LSB +: 3];
  assign newWlm1  = regWrData[CMD_WL_LSB +: WLEN_W];
  assign accept   = cmdWr && !busy &&
                    (newOp == OP_RD1 || newOp == OP_WR1 || newOp == OP_RD2 || newOp == OP_RD4);
  assign endFrame = cmdWr && !busy && (newOp == OP_END);
  assign clkEn    = clkCtrlQ[CLK_EN_BIT];
  assign phaseEnd = busy && clkEn && (divCnt >= clkCtrlQ[DIV_W-1:0]);
  assign isWrite  = (opQ == OP_WR1);

  always_comb begin
    case (newOp)
      OP_RD2:  newLanes = 2'd1;
      OP_RD4:  newLanes = 2'd2;
      default: newLanes = 2'd0;
    endcase
    edgesInit = ({1'b0, newWlm1} >> newLanes) + (WLEN_W+1)'(1);
  end

  // software-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCtrlQ <= '0;
      devCtrlQ <= '0;
      cmdQ     <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_CLK) clkCtrlQ <= regWrData;
      if (regAddr == A_DEV) devCtrlQ <= regWrData;
      if (cmdWr && !busy)   cmdQ     <= regWrData;
    end
  end

  // word sequencer and frame counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      frameOn   <= 1'b0;
      wordDone  <= 1'b0;
      half      <= 1'b0;
      divCnt    <= '0;
      edgesLeft <= '0;
      frameCnt  <= '0;
      frameLast <= '0;
      selCs     <= '0;
      opQ       <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      frameOn   <= 1'b1;
      wordDone  <= 1'b0;
      half      <= 1'b0;
      divCnt    <= '0;
      edgesLeft <= edgesInit;
      frameLast <= regWrData[FLEN_W-1:0];
      selCs     <= regWrData[CMD_CS_LSB +: CS_W];
      opQ       <= newOp;
    end else if (endFrame) begin
      frameOn  <= 1'b0;
      frameCnt <= '0;
      wordDone <= 1'b0;
    end else if (cmdWr && !busy) begin
      wordDone <= 1'b0;
    end else if (busy && clkEn) begin
      if (phaseEnd) begin
        divCnt <= '0;
        half   <= ~half;
        if (half) begin
          if (edgesLeft == (WLEN_W+1)'(1)) begin
            busy     <= 1'b0;
            wordDone <= 1'b1;
            if (frameCnt == frameLast) begin
              frameOn  <= 1'b0;
              frameCnt <= '0;
            end else begin
              frameCnt <= frameCnt + 1'b1;
            end
          end else begin
            edgesLeft <= edgesLeft - 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign dpCtrl.load     = accept && (newOp == OP_WR1);
  assign dpCtrl.clear    = accept && (newOp != OP_WR1);
  assign dpCtrl.alignAmt = WLEN_W'(WORD_MAX - 1) - newWlm1;
  assign dpCtrl.shiftOut = phaseEnd && half && isWrite;
  assign dpCtrl.sampleIn = phaseEnd && !half && !isWrite;
  assign dpCtrl.lanes    = (opQ == OP_RD2) ? 2'd1 : (opQ == OP_RD4) ? 2'd2 : 2'd0;

  assign cpolSel = devCtrlQ[{selCs, 3'b000}];
  assign cphaSel = devCtrlQ[{selCs, 3'b010}];
  assign sclk    = (busy && clkEn) ? (cpolSel ^ (cphaSel ? ~half : half)) : cpolSel;
  assign dataOe  = busy && isWrite;
  assign statusQ = {{(REG_W-2){1'b0}}, wordDone, busy};

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csOut[g] = (frameOn && selCs == CS_W'(g)) ? devCtrlQ[8*g+1] : ~devCtrlQ[8*g+1];
  end

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> frameOn); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordDone) |-> !busy && $past(busy)); // R11
  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> (edgesLeft == $past(edgesLeft)) || (edgesLeft == $past(edgesLeft) - 1'b1)); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    busy && !clkEn |=> $stable(edgesLeft) && $stable(half)); // R13
endmodule

// File: rtl/qspi_cmd_engine.sv
module qspi_cmd_engine
  import qspi_eng_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              sclk,
  output logic [NUM_CS-1:0] csOut,
  output logic              dataOut,
  output logic              dataOe,
  input  logic [3:0]        dataIn
);
  dpCtrl_t          dpCtrl;
  logic [REG_W-1:0] clkCtrlQ, devCtrlQ, cmdQ, statusQ, dataRd;

  qspi_eng_ctrl #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .clkCtrlQ(clkCtrlQ), .devCtrlQ(devCtrlQ), .cmdQ(cmdQ), .statusQ(statusQ),
    .dpCtrl(dpCtrl), .sclk(sclk), .csOut(csOut), .dataOe(dataOe)
  );

  qspi_eng_dp u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .dpCtrl(dpCtrl), .dataIn(dataIn), .dataRd(dataRd), .dataOut(dataOut)
  );

  always_comb begin
    case (regAddr)
      A_CLK:   regRdData = clkCtrlQ;
      A_DEV:   regRdData = devCtrlQ;
      A_CMD:   regRdData = cmdQ;
      A_STAT:  regRdData = statusQ;
      default: regRdData = dataRd;
    endcase
  end
endmodule

// File: tb/qspi_cmd_engine_bench.sv
module qspi_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd3;
  logic [31:0] regWrData = '0;
  wire  [31:0] regRdData;
  wire         sclk, dataOut, dataOe;
  wire  [3:0]  csOut;
  wire  [3:0]  dataIn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // serial device model
  bit           slaveOn = 0;
  bit           cpolB = 0, cphaB = 0;
  logic [1:0]   laneB = 2'd0;
  logic [127:0] slaveTx = '0, slaveRx = '0;
  int           edgeCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_cmd_engine u_qspi_cmd_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .sclk(sclk), .csOut(csOut), .dataOut(dataOut), .dataOe(dataOe),
    .dataIn(dataIn)
  );

  always @(sclk) begin
    if (slaveOn && (sclk === (cpolB ^ !cphaB))) begin
      edgeCount++;
      slaveRx = {slaveRx[126:0], dataOut};
      case (laneB)
        2'd1:    slaveTx = slaveTx << 2;
        2'd2:    slaveTx = slaveTx << 4;
        default: slaveTx = slaveTx << 1;
      endcase
    end
  end

  assign dataIn = (laneB == 2'd2) ? slaveTx[127:124] :
                  (laneB == 2'd1) ? {2'b00, slaveTx[127:126]} : {2'b00, slaveTx[127], 1'b0};

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd3;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 3'd3;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    regAddr = 3'd3;
    #1;
    while (regRdData[0] && cyc < LIMIT) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [31:0] mkCmd(input int cs, input logic [2:0] op, input int wbits, input int flm1);
    return (32'(cs) << 28) | (32'(wbits - 1) << 19) | (32'(op) << 16) | 32'(flm1);
  endfunction

  task automatic doWord(input int cs, input bit cpol, input bit cpha, input bit csHigh, input int dv,
                        input logic [2:0] op, input int wbits, input logic [127:0] pat);
    int cyc, k;
    logic [127:0] mask, got;
    logic [31:0] r;
    bit isWr;
    isWr = (op == 3'd2);
    laneB = (op == 3'd3) ? 2'd1 : (op == 3'd7) ? 2'd2 : 2'd0;
    k = 1 << laneB;
    mask = (wbits == 128) ? '1 : ((128'(1) << wbits) - 128'(1));
    wr(3'd0, 32'h8000_0000 | 32'(dv));
    wr(3'd1, 32'({5'b0, cpha, csHigh, cpol}) << (8 * cs));
    if (isWr) for (int i = 0; i < 4; i++) wr(3'(4 + i), pat[32*i +: 32]);
    cpolB = cpol; cphaB = cpha;
    slaveTx = pat << (128 - wbits);
    slaveRx = '0; edgeCount = 0; slaveOn = 1;
    #1 check(csOut[cs] == !csHigh, "R9 idle cs level", 128'(csOut[cs]), 128'(!csHigh));
    wr(3'd2, mkCmd(cs, op, wbits, 0));
    #1 check(csOut[cs] == csHigh, "R9 cs asserted", 128'(csOut[cs]), 128'(csHigh));
    check(dataOe == isWr, "R5 drive enable", 128'(dataOe), 128'(isWr));
    waitIdle(cyc);
    slaveOn = 0;
    check(cyc == (wbits / k) * 2 * (dv + 1), "R4 busy length", 128'(cyc), 128'((wbits / k) * 2 * (dv + 1)));
    check(edgeCount == wbits / k, "R8 sampling edges", 128'(edgeCount), 128'(wbits / k));
    check(sclk == cpol, "R8 idle sclk", 128'(sclk), 128'(cpol));
    check(csOut[cs] == !csHigh, "R9 cs released", 128'(csOut[cs]), 128'(!csHigh));
    rd(3'd3, r);
    check(r == 32'd2, "R11 status after word", 128'(r), 128'd2);
    if (isWr) begin
      check((slaveRx & mask) == (pat & mask), "R5 write bits", slaveRx & mask, pat & mask);
    end else begin
      for (int i = 0; i < 4; i++) begin
        rd(3'(4 + i), r);
        got[32*i +: 32] = r;
      end
      check(got == (pat & mask), (laneB == 2'd0) ? "R6 single read" : "R7 multi-line read", got, pat & mask);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [127:0] pat;
    logic [31:0] itv;
    int cyc, it, wbits, sclkChanges;
    logic [2:0] op;
    bit lastSclk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(3'd3, r); check(r == 0, "R1 status", 128'(r), 0);
    rd(3'd0, r); check(r == 0, "R1 clock control", 128'(r), 0);
    rd(3'd4, r); check(r == 0, "R1 data0", 128'(r), 0);
    check(csOut == 4'hF && sclk == 1'b0 && dataOe == 1'b0, "R1 pins",
          128'({csOut, sclk, dataOe}), 128'({4'hF, 2'b00}));
    // R2 readback
    wr(3'd1, 32'h1B2A_3C4D); rd(3'd1, r); check(r == 32'h1B2A_3C4D, "R2 device control", 128'(r), 128'(32'h1B2A_3C4D));
    wr(3'd0, 32'h8000_1234); rd(3'd0, r); check(r == 32'h8000_1234, "R2 clock control", 128'(r), 128'(32'h8000_1234));
    for (int i = 0; i < 4; i++) wr(3'(4 + i), 32'hA000_0000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), r);
      check(r == 32'hA000_0000 + 32'(i * 17), "R2 data register", 128'(r), 128'(32'hA000_0000 + 32'(i * 17)));
    end
    // sweep: divider x mode x operation x word length
    it = 0;
    for (int dv = 0; dv < 3; dv++)
      for (int md = 0; md < 4; md++)
        for (int oi = 0; oi < 4; oi++)
          for (int wi = 0; wi < 4; wi++) begin
            op = (oi == 0) ? 3'd2 : (oi == 1) ? 3'd1 : (oi == 2) ? 3'd3 : 3'd7;
            wbits = (wi == 3) ? 128 : (8 << wi);
            itv = 32'(it);
            pat = {32'h1234_5678 ^ (itv * 32'h9E37_79B9), 32'hCAFE_F00D + itv * 32'd7,
                   ~(itv * 32'h0101_0101), 32'h5A5A_0000 | itv};
            doWord(it % 4, md[0], md[1], it[2], dv, op, wbits, pat);
            it++;
          end
    // R9 three-word frame keeps the chip select
    wr(3'd0, 32'h8000_0000);
    wr(3'd1, 32'h0000_0000);
    for (int w = 0; w < 3; w++) begin
      wr(3'd2, mkCmd(2, 3'd2, 8, 2));
      waitIdle(cyc);
      #1 check(csOut[2] == ((w == 2) ? 1'b1 : 1'b0), "R9 frame hold", 128'(csOut[2]), 128'((w == 2) ? 1 : 0));
    end
    // R10 end-of-frame command releases early, R11 done clears on command
    wr(3'd2, mkCmd(1, 3'd1, 16, 5));
    waitIdle(cyc);
    #1 check(csOut[1] == 1'b0, "R10 frame open", 128'(csOut[1]), 0);
    rd(3'd3, r); check(r == 32'd2, "R11 done set", 128'(r), 2);
    wr(3'd2, mkCmd(1, 3'd4, 8, 0));
    #1 check(csOut[1] == 1'b1, "R10 end frame", 128'(csOut[1]), 1);
    rd(3'd3, r); check(r == 32'd0, "R11 done cleared", 128'(r), 0);
    // R3 unknown code starts nothing
    wr(3'd2, mkCmd(0, 3'd5, 8, 0));
    repeat (5) @(negedge clk);
    #1 check(csOut == 4'hF && regRdData == 32'd0, "R3 unknown code", 128'({csOut, regRdData}), 128'({4'hF, 32'd0}));
    // R12 command while busy is ignored
    wr(3'd0, 32'h8000_0003);
    wr(3'd2, mkCmd(1, 3'd2, 32, 0));
    wr(3'd2, mkCmd(3, 3'd7, 8, 0));
    waitIdle(cyc);
    check(cyc == 254, "R12 busy length kept", 128'(cyc), 254);
    rd(3'd2, r); check(r == mkCmd(1, 3'd2, 32, 0), "R12 command register", 128'(r), 128'(mkCmd(1, 3'd2, 32, 0)));
    repeat (10) @(negedge clk);
    #1 check(csOut == 4'hF && regRdData == 32'd2, "R12 no second word", 128'({csOut, regRdData}), 128'({4'hF, 32'd2}));
    // R13 disabled clock stalls the word
    wr(3'd0, 32'h0000_0000);
    wr(3'd2, mkCmd(0, 3'd2, 8, 0));
    sclkChanges = 0; lastSclk = sclk;
    repeat (20) begin
      @(negedge clk);
      if (sclk != lastSclk) sclkChanges++;
      lastSclk = sclk;
    end
    #1 check(regRdData[0] == 1'b1 && sclkChanges == 0, "R13 stalled", 128'({regRdData[0], 8'(sclkChanges)}), 128'({1'b1, 8'd0}));
    wr(3'd0, 32'h8000_0000);
    waitIdle(cyc);
    check(cyc == 16 && regRdData == 32'd2, "R13 resumed", 128'(cyc), 16);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule